// File: doc/BRIEF.md
# Thermal Alarm Event Controller

This block holds the configuration register that governs a temperature sensor's alarm output. Three comparison flags come in from the trip-limit logic: below the alarm window, above the alarm window, and above the critical limit. The block turns them into one event pin. The pin can be disabled, inverted, limited to critical conditions only, and run either as a live comparator or as a latch that firmware clears.

Two sticky lock bits protect the trip-limit registers, which sit outside this block. The block exports the lock states so those registers can refuse writes. Only the power-on reset can clear a lock. While a lock is set, the register also freezes the configuration fields that shape the event pin.

Software writes one byte at a time through `wr_en`/`wr_data`. `rd_data` always presents the current readback value.

Top module: `therm_evt_ctrl`

## Requirements
- R1: While `por_n` is low, and after it is released, every register bit is 0 and the interrupt latch is clear. With these values `rd_data` is 0x00 and `evt_pin` is 1, the inactive level for active-low polarity.
- R2: Writing 1 to bit 7 sets the critical lock and writing 1 to bit 6 sets the window lock, each in a single write. A set lock reads back as 1 and drives `crit_locked` or `win_locked` high. Writing 0 to a set lock never clears it; only `por_n` low does.
- R3: While either lock is set, writes leave bit 3 (enable), bit 1 (polarity) and bit 0 (mode) unchanged. While the window lock is set, writes also leave bit 2 (critical-only) unchanged. A write uses the lock state from before that write, so in a partly blocked write the bits that are not frozen still take the written value.
- R4: Bit 5 always reads 0. Writing 1 to it clears the interrupt latch in interrupt mode and has no effect in comparator mode.
- R5: Bit 4 reads 1 exactly when the block is asserting the event pin. Writes to bit 4 are ignored.
- R6: With bit 2 = 0, the qualifying condition is any of the three flags. With bit 2 = 1, only `flag_crit` qualifies.
- R7: In comparator mode (bit 0 = 0), the asserted state follows the qualifying condition in the same cycle.
- R8: In interrupt mode (bit 0 = 1), a rising qualifying condition sets a latch, visible right after that clock edge. The latch holds until a clear is written. If a rise and a clear fall on the same edge, the rise wins.
- R9: With bit 3 = 0, `evt_pin` holds the inactive level for the selected polarity and bit 4 reads 0.
- R10: With bit 1 = 0 the asserted pin level is low; with bit 1 = 1 it is high.
- R11: `rd_data` bit order, MSB to LSB: critical lock, window lock, 0, status, enable, critical-only, polarity, mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| flag_below | input | 1 | Temperature is below the alarm window |
| flag_above | input | 1 | Temperature is above the alarm window |
| flag_crit | input | 1 | Temperature is above the critical limit |
| rd_data | output | 8 | Readback value |
| crit_locked | output | 1 | Critical trip register is write-protected |
| win_locked | output | 1 | Alarm window trip registers are write-protected |
| evt_pin | output | 1 | Event output level |

## Verification
A register write takes effect at the clock edge that samples `wr_en`. Its readback, the lock outputs and any change in pin behaviour are therefore due in the cycle right after that edge.

In comparator mode the pin follows the flags with no register in the path. In interrupt mode the latch adds one edge, so a rising flag shows on the pin just after the edge that samples it.

The bench drives every input on the falling edge and holds it through the next rising edge. It samples one nanosecond after that rising edge. Each check therefore sees both the registered result of its own stimulus and the combinational response to the inputs still held.

// File: rtl/therm_evt_pkg.sv
package therm_evt_pkg;
    localparam int REG_W   = 8;
    localparam int B_LCRIT = 7;
    localparam int B_LWIN  = 6;
    localparam int B_CLR   = 5;
    localparam int B_STAT  = 4;
    localparam int B_OE    = 3;
    localparam int B_CONLY = 2;
    localparam int B_POL   = 1;
    localparam int B_MODE  = 0;

    typedef struct packed {
        logic lock_crit;
        logic lock_win;
        logic oe;
        logic crit_only;
        logic pol;
        logic mode;
    } cfg_t;

    typedef struct packed {
        logic latch;
        logic cond_prev;
    } evt_st_t;
endpackage

// File: rtl/therm_evt_cfg.sv
module therm_evt_cfg
    import therm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic             clr_stb
);
    cfg_t cfg_d, cfg_q;
    logic any_lock;
    logic stat_wr_unused;

    assign stat_wr_unused = wr_data[B_STAT];

    always_comb begin
        any_lock = cfg_q.lock_crit | cfg_q.lock_win;
        cfg_d    = cfg_q;
        if (wr_en) begin
            cfg_d.lock_crit = cfg_q.lock_crit | wr_data[B_LCRIT];
            cfg_d.lock_win  = cfg_q.lock_win  | wr_data[B_LWIN];
            if (!any_lock) begin
                cfg_d.oe   = wr_data[B_OE];
                cfg_d.pol  = wr_data[B_POL];
                cfg_d.mode = wr_data[B_MODE];
            end
            if (!cfg_q.lock_win) begin
                cfg_d.crit_only = wr_data[B_CONLY];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg     = cfg_q;
    assign clr_stb = wr_en & wr_data[B_CLR];

    a_r2_crit_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.lock_crit |=> cfg_q.lock_crit);
    a_r2_win_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.lock_win |=> cfg_q.lock_win);
    a_r3_shared_freeze: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_q.lock_crit || cfg_q.lock_win) |=> $stable({cfg_q.oe, cfg_q.pol, cfg_q.mode}));
    a_r3_window_freeze: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.lock_win |=> $stable(cfg_q.crit_only));
endmodule

// File: rtl/therm_evt_core.sv
module therm_evt_core
    import therm_evt_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  cfg_t cfg,
    input  logic clr_stb,
    input  logic flag_below,
    input  logic flag_above,
    input  logic flag_crit,
    output logic active,
    output logic pin
);
    evt_st_t st_d, st_q;
    logic cond;
    logic rise;
    logic raw;

    always_comb begin
        cond = cfg.crit_only ? flag_crit : (flag_crit | flag_above | flag_below);
        rise = cond & ~st_q.cond_prev;
        st_d = st_q;
        st_d.cond_prev = cond;
        if (!cfg.mode)    st_d.latch = 1'b0;
        else if (rise)    st_d.latch = 1'b1;
        else if (clr_stb) st_d.latch = 1'b0;
        raw    = cfg.mode ? st_q.latch : cond;
        active = cfg.oe & raw;
        pin    = cfg.pol ? active : ~active;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_rise_sets_latch: assert property (@(posedge clk) disable iff (!por_n)
        (cfg.mode && cond && !st_q.cond_prev) |=> st_q.latch);
    a_r8_latch_holds: assert property (@(posedge clk) disable iff (!por_n)
        (cfg.mode && st_q.latch && !clr_stb) |=> st_q.latch);
endmodule

// File: rtl/therm_evt_ctrl.sv
module therm_evt_ctrl
    import therm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             flag_below,
    input  logic             flag_above,
    input  logic             flag_crit,
    output logic [REG_W-1:0] rd_data,
    output logic             crit_locked,
    output logic             win_locked,
    output logic             evt_pin
);
    cfg_t cfg;
    logic clr_stb;
    logic active;

    therm_evt_cfg u_cfg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .clr_stb (clr_stb)
    );

    therm_evt_core u_core (
        .clk        (clk),
        .por_n      (por_n),
        .cfg        (cfg),
        .clr_stb    (clr_stb),
        .flag_below (flag_below),
        .flag_above (flag_above),
        .flag_crit  (flag_crit),
        .active     (active),
        .pin        (evt_pin)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[B_LCRIT] = cfg.lock_crit;
        rd_data[B_LWIN]  = cfg.lock_win;
        rd_data[B_STAT]  = active;
        rd_data[B_OE]    = cfg.oe;
        rd_data[B_CONLY] = cfg.crit_only;
        rd_data[B_POL]   = cfg.pol;
        rd_data[B_MODE]  = cfg.mode;
    end

    assign crit_locked = cfg.lock_crit;
    assign win_locked  = cfg.lock_win;

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!por_n)
        !rd_data[B_OE] |-> (!rd_data[B_STAT] && (evt_pin == !rd_data[B_POL])));
    a_r5_status_matches_pin: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[B_STAT] == (evt_pin == rd_data[B_POL]));
    a_r1_reset_idle: assert property (@(posedge clk)
        !por_n |-> (rd_data == '0 && evt_pin));
endmodule

// File: tb/tb_therm_evt_ctrl.sv
`timescale 1ns/1ps
module tb_therm_evt_ctrl;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flag_below = 1'b0, flag_above = 1'b0, flag_crit = 1'b0;
    logic [7:0] rd_data;
    logic       crit_locked, win_locked, evt_pin;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    therm_evt_ctrl dut (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
        .flag_below(flag_below), .flag_above(flag_above), .flag_crit(flag_crit),
        .rd_data(rd_data), .crit_locked(crit_locked), .win_locked(win_locked),
        .evt_pin(evt_pin)
    );

    // {we, wdata, flags{crit,above,below}, expected rd_data, expected pin}
    localparam int NV = 21;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h00, 3'b000, 8'h00, 1'b1},  // R1 idle after reset
        {1'b1, 8'h08, 3'b000, 8'h08, 1'b1},  // R11 enable
        {1'b0, 8'h00, 3'b001, 8'h18, 1'b0},  // R7 R6 below flag, comparator
        {1'b0, 8'h00, 3'b000, 8'h08, 1'b1},  // R7 follows condition
        {1'b0, 8'h00, 3'b010, 8'h18, 1'b0},  // R6 above flag
        {1'b1, 8'h28, 3'b010, 8'h18, 1'b0},  // R4 clear ignored in comparator, reads 0
        {1'b1, 8'h0C, 3'b011, 8'h0C, 1'b1},  // R6 critical-only masks window flags
        {1'b0, 8'h00, 3'b100, 8'h1C, 1'b0},  // R6 critical flag qualifies
        {1'b1, 8'h0A, 3'b000, 8'h0A, 1'b0},  // R10 active high, idle low
        {1'b0, 8'h00, 3'b001, 8'h1A, 1'b1},  // R10 asserted high
        {1'b1, 8'h12, 3'b001, 8'h02, 1'b0},  // R5 R9 status write ignored, disabled
        {1'b1, 8'h0B, 3'b000, 8'h0B, 1'b0},  // R8 interrupt mode
        {1'b0, 8'h00, 3'b100, 8'h1B, 1'b1},  // R8 rise sets latch
        {1'b0, 8'h00, 3'b000, 8'h1B, 1'b1},  // R8 latch holds
        {1'b1, 8'h2B, 3'b000, 8'h0B, 1'b0},  // R4 clear in interrupt mode
        {1'b0, 8'h00, 3'b001, 8'h1B, 1'b1},  // R8 new rise
        {1'b1, 8'h2B, 3'b001, 8'h0B, 1'b0},  // R4 clear while condition held
        {1'b0, 8'h00, 3'b000, 8'h0B, 1'b0},  // R8 no retrigger
        {1'b1, 8'h40, 3'b000, 8'h40, 1'b1},  // R3 lock set, same write updates rest
        {1'b1, 8'h0F, 3'b000, 8'h40, 1'b1},  // R3 frozen by window lock
        {1'b1, 8'h00, 3'b000, 8'h40, 1'b1}   // R2 lock not cleared by write
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] wd, input logic [2:0] fl);
        @(negedge clk);
        wr_en = we; wr_data = wd;
        {flag_crit, flag_above, flag_below} = fl;
        @(posedge clk);
        #1;
    endtask

    task automatic por_pulse();
        @(negedge clk);
        por_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        {flag_crit, flag_above, flag_below} = 3'b000;
        @(negedge clk);
        chk("R1 rd during reset", rd_data, 8'h00);
        chk("R1 pin during reset", {7'd0, evt_pin}, 8'h01);
        por_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd in reset", rd_data, 8'h00);
        chk("R1 locks in reset", {6'd0, crit_locked, win_locked}, 8'h00);
        por_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][20], VEC[i][19:12], VEC[i][11:9]);
            chk($sformatf("R11 vec %0d rd", i), rd_data, VEC[i][8:1]);
            chk($sformatf("R10 vec %0d pin", i), {7'd0, evt_pin}, {7'd0, VEC[i][0]});
            chk($sformatf("R2 vec %0d locks", i), {6'd0, crit_locked, win_locked},
                {6'd0, VEC[i][8:7]});
        end

        // R2: only power-on reset releases a lock
        por_pulse();
        step(1'b0, 8'h00, 3'b000);
        chk("R1 R2 rd after por", rd_data, 8'h00);
        chk("R2 locks after por", {6'd0, crit_locked, win_locked}, 8'h00);

        // R3: critical lock alone leaves bit 2 writable
        step(1'b1, 8'h80, 3'b000);
        chk("R2 crit lock set", rd_data, 8'h80);
        chk("R2 crit_locked", {6'd0, crit_locked, win_locked}, 8'h02);
        step(1'b1, 8'h04, 3'b000);
        chk("R3 bit2 writable under crit lock", rd_data, 8'h84);
        step(1'b1, 8'h0F, 3'b000);
        chk("R3 bits 3,1,0 frozen under crit lock", rd_data, 8'h84);
        step(1'b1, 8'h43, 3'b000);
        chk("R3 partial write", rd_data, 8'hC0);
        step(1'b1, 8'h04, 3'b000);
        chk("R3 bit2 frozen under window lock", rd_data, 8'hC0);
        chk("R9 pin idle while disabled", {7'd0, evt_pin}, 8'h01);

        // R8: rise and clear on the same edge, rise wins
        por_pulse();
        step(1'b1, 8'h0B, 3'b000);
        chk("R8 setup", rd_data, 8'h0B);
        step(1'b1, 8'h2B, 3'b001);
        chk("R8 rise beats clear rd", rd_data, 8'h1B);
        chk("R8 rise beats clear pin", {7'd0, evt_pin}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule